// File: doc/BRIEF.md
# Serial Display-Memory Host Port

This block is the host-facing serial port of a memory-mapped LCD controller. The host uses four pins. It pulls an active-low select, clocks bits in on rising edges of a write strobe, and clocks bits out on rising edges of a separate read strobe. All data moves over a single shared data line. Every transfer opens with a 3-bit operation code, sent most significant bit first. The code picks one of three operations: write the display memory, read the display memory, or load command words.

The display memory holds 64 words of 8 bits. A memory operation sends a 6-bit word address after the code. Data then moves in 4-bit nibbles, least significant bit first. The first nibble at a word is its low half and the second is its high half. An internal nibble pointer moves forward by itself, and the word address therefore steps after every high half. In read mode the host may write a nibble back into the location it has just read, which gives read-modify-write access. Command words go to a command register with a one-cycle strobe, for the rest of the controller to decode. A separate port gives the display scan logic a read view of the memory. The block drives the pad's output enable itself.

All pins are sampled on the system clock. Strobe phases must therefore last at least three system clock cycles.

Top module: `tw_ram_port`

## Requirements
- R1: While the select is high, strobes have no effect and the serial state returns to waiting for an operation code; a partly sent nibble or command is discarded.
- R2: The 3-bit code (first bit is bit 2) selects the operation: 101 writes memory, 110 reads memory, 100 loads commands; any other code makes the rest of that selection ignored.
- R3: In both memory operations the code is followed by a 6-bit word address, sent most significant bit first, which sets the pointer to the low half of that word.
- R4: In write mode every 4 write-strobe bits (first bit lands in nibble bit 0) store one nibble: the low half is bits 3:0 and the high half is bits 7:4 of the word. The pointer moves on after each nibble.
- R5: In read mode each read-strobe rising edge drives the next bit of the current nibble onto the data output, starting at nibble bit 0, with low half before high half.
- R6: The nibble pointer moves forward by itself, so the word address steps after each high half and wraps from word 63 to word 0.
- R7: In read mode, four write-strobe bits after a completed read nibble overwrite that same nibble, and a later read continues at the following nibble.
- R8: In command mode every 9 write-strobe bits (most significant bit first) update the 9-bit command output and raise the command strobe for exactly one cycle; several commands may follow one another within one selection.
- R9: The output enable is high only in the read data phase, from a read-strobe rising edge until a write-strobe falling edge or the end of the selection.
- R10: The display port returns the full 8-bit word at its address, with no added clock delay.
- R11: After reset the command output is 0, the command strobe and output enable are low, and every memory word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| rd_n | input | 1 | Read strobe; the next bit is driven on its rising edge |
| sdata_i | input | 1 | Data line value seen at the pad |
| sdata_o | output | 1 | Data bit driven to the pad |
| sdata_oe | output | 1 | Pad output enable |
| cmd_word | output | 9 | Last complete command word |
| cmd_stb | output | 1 | One-cycle pulse when cmd_word updates |
| disp_addr | input | 6 | Display scan word address |
| disp_word | output | 8 | Memory word at disp_addr |

## Verification
The bench builds the block with its default widths: a 6-bit address, 4-bit nibbles, 8-bit words and a 9-bit command. With only 64 words, a transfer that starts at word 63 reaches the wrap to word 0 in its second word. Random address and length runs also wrap now and then, and the bench compares both the serial read-back and the display port against its own memory model. Because the nibble is only 4 bits, read-modify-write and aborted partial nibbles are each a few strobes long and can be directed exactly.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int ID_W = 3;

    localparam logic [ID_W-1:0] OP_WRITE = 3'b101;
    localparam logic [ID_W-1:0] OP_READ  = 3'b110;
    localparam logic [ID_W-1:0] OP_CMD   = 3'b100;

    typedef enum logic [2:0] {
        PH_OP,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_CMD,
        PH_HALT
    } phase_e;

endpackage

// File: rtl/tw_pin_sampler.sv
module tw_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    input  logic din,
    output logic active,
    output logic wr_rise,
    output logic wr_fall,
    output logic rd_rise,
    output logic bit_o
);

    typedef struct packed {
        logic cs;
        logic wr;
        logic rd;
        logic d;
        logic wr_p;
        logic rd_p;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cs   = cs_n;
        smp_d.wr   = wr_n;
        smp_d.rd   = rd_n;
        smp_d.d    = din;
        smp_d.wr_p = smp_q.wr;
        smp_d.rd_p = smp_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '{cs: 1'b1, wr: 1'b1, rd: 1'b1, d: 1'b0, wr_p: 1'b1, rd_p: 1'b1};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign active  = ~smp_q.cs;
    assign wr_rise = smp_q.wr & ~smp_q.wr_p;
    assign wr_fall = ~smp_q.wr & smp_q.wr_p;
    assign rd_rise = smp_q.rd & ~smp_q.rd_p;
    assign bit_o   = smp_q.d;

endmodule

// File: rtl/tw_disp_ram.sv
module tw_disp_ram #(
    parameter int ADDR_W = 6,
    parameter int NIB_W  = 4,
    parameter int WORD_W = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         we,
    input  logic [ADDR_W+$clog2(WORD_W/NIB_W)-1:0]       wptr,
    input  logic [NIB_W-1:0]                             wnib,
    input  logic [ADDR_W+$clog2(WORD_W/NIB_W)-1:0]       rptr,
    output logic [NIB_W-1:0]                             rnib,
    input  logic [ADDR_W-1:0]                            daddr,
    output logic [WORD_W-1:0]                            dword
);

    localparam int HALF_W = $clog2(WORD_W / NIB_W);
    localparam int PTR_W  = ADDR_W + HALF_W;
    localparam int DEPTH  = 2 ** ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[wptr[PTR_W-1:HALF_W]][int'(wptr[HALF_W-1:0])*NIB_W +: NIB_W] <= wnib;
        end
    end

    assign rnib  = mem_q[rptr[PTR_W-1:HALF_W]][int'(rptr[HALF_W-1:0])*NIB_W +: NIB_W];
    assign dword = mem_q[daddr];

endmodule

// File: rtl/tw_ram_port.sv
module tw_ram_port #(
    parameter int ADDR_W = 6,
    parameter int NIB_W  = 4,
    parameter int WORD_W = 8,
    parameter int CMD_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              sdata_i,
    output logic              sdata_o,
    output logic              sdata_oe,
    output logic [CMD_W-1:0]  cmd_word,
    output logic              cmd_stb,
    input  logic [ADDR_W-1:0] disp_addr,
    output logic [WORD_W-1:0] disp_word
);

    import tw_pkg::*;

    localparam int HALF_W = $clog2(WORD_W / NIB_W);
    localparam int PTR_W  = ADDR_W + HALF_W;
    localparam int NB_W   = $clog2(NIB_W);
    localparam int MAXB_A = (CMD_W > ADDR_W) ? CMD_W : ADDR_W;
    localparam int SH_W   = (MAXB_A > NIB_W) ? MAXB_A : NIB_W;
    localparam int CNT_W  = $clog2(SH_W + 1);

    typedef struct packed {
        phase_e             ph;
        logic               mode_rd;
        logic [CNT_W-1:0]   cnt;
        logic [SH_W-1:0]    sh;
        logic [PTR_W-1:0]   ptr;
        logic               rd_done;
        logic               dout;
        logic               oe;
        logic [CMD_W-1:0]   cmd;
        logic               stb;
    } st_t;

    st_t st_d, st_q;

    logic             active, wr_rise, wr_fall, rd_rise, din;
    logic             ram_we;
    logic [PTR_W-1:0] ram_rptr;
    logic [NIB_W-1:0] ram_wnib, ram_rnib;
    logic [SH_W-1:0]  msb_shift;
    logic [NIB_W-1:0] lsb_shift;

    tw_pin_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .din     (sdata_i),
        .active  (active),
        .wr_rise (wr_rise),
        .wr_fall (wr_fall),
        .rd_rise (rd_rise),
        .bit_o   (din)
    );

    tw_disp_ram #(
        .ADDR_W (ADDR_W),
        .NIB_W  (NIB_W),
        .WORD_W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .wptr  (st_q.ptr),
        .wnib  (ram_wnib),
        .rptr  (ram_rptr),
        .rnib  (ram_rnib),
        .daddr (disp_addr),
        .dword (disp_word)
    );

    assign msb_shift = {st_q.sh[SH_W-2:0], din};
    assign lsb_shift = {din, st_q.sh[NIB_W-1:1]};
    assign ram_wnib  = lsb_shift;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        ram_we   = 1'b0;
        ram_rptr = st_q.ptr;
        if (st_q.rd_done && (st_q.cnt == '0)) begin
            ram_rptr = st_q.ptr + 1'b1;
        end

        if (!active) begin
            st_d.ph      = PH_OP;
            st_d.mode_rd = 1'b0;
            st_d.cnt     = '0;
            st_d.sh      = '0;
            st_d.rd_done = 1'b0;
            st_d.oe      = 1'b0;
        end else begin
            if (wr_fall) begin
                st_d.oe = 1'b0;
            end
            if (wr_rise) begin
                st_d.cnt = st_q.cnt + 1'b1;
                unique case (st_q.ph)
                    PH_OP: begin
                        st_d.sh = msb_shift;
                        if (st_q.cnt == CNT_W'(ID_W - 1)) begin
                            st_d.cnt = '0;
                            st_d.sh  = '0;
                            case (msb_shift[ID_W-1:0])
                                OP_WRITE: begin st_d.ph = PH_ADDR; st_d.mode_rd = 1'b0; end
                                OP_READ:  begin st_d.ph = PH_ADDR; st_d.mode_rd = 1'b1; end
                                OP_CMD:   st_d.ph = PH_CMD;
                                default:  st_d.ph = PH_HALT;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        st_d.sh = msb_shift;
                        if (st_q.cnt == CNT_W'(ADDR_W - 1)) begin
                            st_d.cnt     = '0;
                            st_d.sh      = '0;
                            st_d.ptr     = {msb_shift[ADDR_W-1:0], {HALF_W{1'b0}}};
                            st_d.rd_done = 1'b0;
                            st_d.ph      = st_q.mode_rd ? PH_RDATA : PH_WDATA;
                        end
                    end
                    PH_WDATA, PH_RDATA: begin
                        st_d.sh[NIB_W-1:0] = lsb_shift;
                        if (st_q.cnt == CNT_W'(NIB_W - 1)) begin
                            ram_we       = 1'b1;
                            st_d.cnt     = '0;
                            st_d.ptr     = st_q.ptr + 1'b1;
                            st_d.rd_done = 1'b0;
                        end
                    end
                    PH_CMD: begin
                        st_d.sh = msb_shift;
                        if (st_q.cnt == CNT_W'(CMD_W - 1)) begin
                            st_d.cnt = '0;
                            st_d.sh  = '0;
                            st_d.cmd = msb_shift[CMD_W-1:0];
                            st_d.stb = 1'b1;
                        end
                    end
                    default: st_d.cnt = st_q.cnt;
                endcase
            end
            if (rd_rise && (st_q.ph == PH_RDATA)) begin
                st_d.ptr     = ram_rptr;
                st_d.rd_done = 1'b0;
                st_d.dout    = ram_rnib[st_q.cnt[NB_W-1:0]];
                st_d.oe      = 1'b1;
                st_d.cnt     = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(NIB_W - 1)) begin
                    st_d.cnt     = '0;
                    st_d.rd_done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_OP, mode_rd: 1'b0, cnt: '0, sh: '0, ptr: '0,
                      rd_done: 1'b0, dout: 1'b0, oe: 1'b0, cmd: '0, stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sdata_o  = st_q.dout;
    assign sdata_oe = st_q.oe;
    assign cmd_word = st_q.cmd;
    assign cmd_stb  = st_q.stb;

endmodule

// File: rtl/tw_ram_port_chk.sv
module tw_ram_port_chk #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 8,
    parameter int CMD_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              sdata_oe,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              cmd_stb,
    input logic [ADDR_W-1:0] disp_addr,
    input logic [WORD_W-1:0] disp_word
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 1'b1;
        end
    end

    // R9
    oe_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(cs_n, 2)) |-> !sdata_oe);

    // R8
    cmd_strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R8
    cmd_word_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !cmd_stb) |-> $stable(cmd_word));

    // R10
    disp_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $past(wr_n) && $past(wr_n, 2) && $past(wr_n, 3)
         && $stable(disp_addr)) |-> $stable(disp_word));

endmodule

bind tw_ram_port tw_ram_port_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .CMD_W  (CMD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .sdata_oe  (sdata_oe),
    .cmd_word  (cmd_word),
    .cmd_stb   (cmd_stb),
    .disp_addr (disp_addr),
    .disp_word (disp_word)
);

// File: tb/sim_tw_ram_port.sv
module sim_tw_ram_port;

    localparam int AW = 6;
    localparam int WW = 8;
    localparam int CW = 9;
    localparam int DEPTH = 2 ** AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          sdata_i = 1'b0;
    logic          sdata_o, sdata_oe, cmd_stb;
    logic [CW-1:0] cmd_word;
    logic [AW-1:0] disp_addr = '0;
    logic [WW-1:0] disp_word;

    int checks = 0;
    int fails = 0;
    int stb_cnt = 0;
    bit done = 1'b0;
    logic [WW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    tw_ram_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .sdata_i   (sdata_i),
        .sdata_o   (sdata_o),
        .sdata_oe  (sdata_oe),
        .cmd_word  (cmd_word),
        .cmd_stb   (cmd_stb),
        .disp_addr (disp_addr),
        .disp_word (disp_word)
    );

    always @(posedge clk) if (cmd_stb) stb_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wbit(input logic b);
        sdata_i = b; wr_n = 1'b0; tick(3);
        wr_n = 1'b1; tick(3);
    endtask

    task automatic rbit(output logic b);
        rd_n = 1'b0; tick(3);
        rd_n = 1'b1; tick(4);
        b = sdata_o;
    endtask

    task automatic open_op(input logic [2:0] op);
        cs_n = 1'b0; tick(2);
        for (int i = 2; i >= 0; i--) wbit(op[i]);
    endtask

    task automatic close_op();
        cs_n = 1'b1; tick(3);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        for (int i = AW - 1; i >= 0; i--) wbit(a[i]);
    endtask

    function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input int k);
        return AW'((int'(a) + k) % DEPTH);
    endfunction

    task automatic write_run(input logic [AW-1:0] a, input int n);
        open_op(3'b101); send_addr(a);
        for (int k = 0; k < n; k++) begin
            logic [WW-1:0] w;
            w = WW'($urandom);
            model[step(a, k)] = w;
            for (int i = 0; i < WW; i++) wbit(w[i]);
        end
        close_op();
    endtask

    task automatic read_run(input logic [AW-1:0] a, input int n, input string req);
        open_op(3'b110); send_addr(a);
        for (int k = 0; k < n; k++) begin
            logic [WW-1:0] got;
            for (int i = 0; i < WW; i++) begin
                logic b;
                rbit(b);
                got[i] = b;
            end
            chk(req, got, model[step(a, k)]);
        end
        close_op();
    endtask

    task automatic check_disp(input logic [AW-1:0] a, input string req);
        disp_addr = a; tick(1);
        chk(req, disp_word, model[a]);
    endtask

    initial begin
        logic b;
        logic [3:0] nib;
        int base;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        tick(3); rst_n = 1'b1; tick(2);

        // R11 reset state
        chk("R11 cmd_word", cmd_word, 0);
        chk("R11 cmd_stb", cmd_stb, 0);
        chk("R11 oe", sdata_oe, 0);
        check_disp(6'd17, "R11 mem zero");

        // R4 R10 directed write, word layout
        open_op(3'b101); send_addr(6'd5);
        for (int i = 0; i < 8; i++) wbit(logic'((8'hA5 >> i) & 1));
        close_op();
        model[5] = 8'hA5;
        check_disp(6'd5, "R4 word A5");

        // R4 R3 single nibble lands in low half only
        open_op(3'b101); send_addr(6'd10);
        for (int i = 0; i < 4; i++) wbit(logic'((4'h7 >> i) & 1));
        close_op();
        model[10][3:0] = 4'h7;
        check_disp(6'd10, "R4 low half");

        // R6 wrap from last word to zero
        write_run(6'd63, 2);
        check_disp(6'd63, "R6 last word");
        check_disp(6'd0, "R6 wrapped word");
        read_run(6'd63, 2, "R6 read across wrap");

        // R5 R9 read directed, enable timing
        open_op(3'b110); send_addr(6'd5);
        chk("R9 oe low before first read edge", sdata_oe, 0);
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            chk("R5 read bit", b, model[5][i]);
            chk("R9 oe high in read phase", sdata_oe, 1);
        end
        close_op();
        chk("R9 oe low after deselect", sdata_oe, 0);

        // R7 read-modify-write
        open_op(3'b110); send_addr(6'd20);
        for (int i = 0; i < 4; i++) begin rbit(b); nib[i] = b; end
        chk("R7 read low nibble", nib, model[20][3:0]);
        sdata_i = 1'b1; wr_n = 1'b0; tick(3);
        chk("R9 oe drops on write strobe", sdata_oe, 0);
        wr_n = 1'b1; tick(3);
        wbit(1'b0); wbit(1'b0); wbit(1'b1);
        model[20][3:0] = 4'h9;
        for (int i = 0; i < 4; i++) begin rbit(b); nib[i] = b; end
        chk("R7 next read is high half", nib, model[20][7:4]);
        close_op();
        check_disp(6'd20, "R7 written back");

        // R8 two command words in one selection
        base = stb_cnt;
        open_op(3'b100);
        for (int i = CW - 1; i >= 0; i--) wbit(logic'((9'h1A3 >> i) & 1));
        chk("R8 first command", cmd_word, 9'h1A3);
        for (int i = CW - 1; i >= 0; i--) wbit(logic'((9'h05C >> i) & 1));
        chk("R8 second command", cmd_word, 9'h05C);
        close_op();
        chk("R8 strobe count", stb_cnt - base, 2);

        // R1 aborted partial nibble, strobes while deselected
        open_op(3'b101); send_addr(6'd30);
        wbit(1'b1); wbit(1'b1);
        close_op();
        check_disp(6'd30, "R1 partial nibble dropped");
        for (int i = 0; i < 5; i++) wbit(1'b1);
        base = stb_cnt;
        open_op(3'b100);
        for (int i = 0; i < 5; i++) wbit(1'b1);
        close_op();
        chk("R1 partial command dropped", stb_cnt - base, 0);
        write_run(6'd31, 1);
        check_disp(6'd31, "R1 fresh transfer aligned");
        check_disp(6'd30, "R1 neighbour untouched");

        // R2 unknown code ignored
        base = stb_cnt;
        open_op(3'b111);
        for (int i = 0; i < 23; i++) wbit(1'b1);
        close_op();
        check_disp(6'd63, "R2 unknown code no write");
        chk("R2 unknown code no command", stb_cnt - base, 0);
        chk("R2 unknown code oe", sdata_oe, 0);

        // R4 R5 R6 random runs
        for (int it = 0; it < 24; it++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom % DEPTH);
            n = 1 + int'($urandom % 4);
            write_run(a, n);
            read_run(a, n, "R5 random read-back");
            check_disp(step(a, n - 1), "R4 random display view");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule